// File: doc/BRIEF.md
# External Interrupt Edge/Level Detector

This block turns an asynchronous, active-low external interrupt pin into a clean request for the CPU's exception sequencer. The pin goes through a chain of synchronizer flops. A falling edge of the synchronized signal sets an edge latch. The latch stays set until the CPU acknowledges the interrupt. The acknowledge is a one-cycle pulse on `irq_ack`.

A sensitivity option chooses how the raw request is formed:
- **Edge-only mode:** the raw request is the edge latch alone.
- **Level mode:** the raw request is the edge latch OR the live low level of the synchronized pin.

The option is registered inside the block and resets to edge-only. The raw request appears on `irq_status`. It is gated by the CPU interrupt-mask bit to form `irq_req`.

Top module: `ext_irq_detect`

## Requirements
- R1: While reset is asserted and directly after it is released, `irq_status` and `irq_req` are 0. The synchronizer resets to the idle-high pin state, the edge latch resets to 0, and the registered sensitivity mode resets to edge-only.
- R2: In edge-only mode, a falling edge on `irq_pin_n` sets `irq_status` on the third rising clock edge after the pin change, and not before. The bit stays 1 after the pin returns high, until an acknowledge.
- R3: In edge-only mode, the pin level is ignored. A pin held low after an acknowledge leaves `irq_status` at 0 until a new falling edge occurs.
- R4: In level mode (`level_mode`=1, sampled one clock earlier), a low pin raises `irq_status` on the second rising edge after the pin change. It stays raised after an acknowledge for as long as the pin is held low. A low pulse of one clock cycle is still captured by the edge latch.
- R5: `irq_req` equals `irq_status` while `cpu_imask` is 0 and is 0 while `cpu_imask` is 1. The mask acts combinationally, with no added clock delay.
- R6: An `irq_ack` pulse with no coincident falling edge clears the edge latch at that clock edge.
- R7: A falling edge detected in the same cycle as `irq_ack` leaves the edge latch set, so the new edge is not lost.
- R8: A rising edge of the pin never sets the edge latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| level_mode | input | 1 | Sensitivity option: 1 = edge OR low level, 0 = edge only |
| cpu_imask | input | 1 | CPU interrupt-mask bit, 1 blocks the request |
| irq_ack | input | 1 | One-cycle acknowledge from the CPU, clears the edge latch |
| irq_req | output | 1 | Masked request to the exception sequencer |
| irq_status | output | 1 | Unmasked raw request |

## Verification
A pin change is seen at level-mode `irq_status` two rising edges later and at edge-mode `irq_status` three rising edges later. An acknowledge takes effect at the rising edge on which it is sampled. The mask reaches `irq_req` within the same cycle.

The bench drives all inputs on falling clock edges and counts whole cycles before it samples on a later falling edge. In edge-only mode it checks that the status is still 0 one cycle before it is due and 1 in the cycle it is due. Mask checks are sampled one time step after the mask changes, with no clock edge between.

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_pin_n,
  input  logic level_mode,
  input  logic cpu_imask,
  input  logic irq_ack,
  output logic irq_req,
  output logic irq_status
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          prev_q;
  logic          edge_q;
  logic          level_q;
  logic          pin_s;
  logic          fall;

  assign pin_s = sync_q[LAST];
  assign fall  = prev_q & ~pin_s;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= irq_pin_n;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[LAST-1:0], irq_pin_n};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      edge_q  <= 1'b0;
      level_q <= 1'b0;
    end else begin
      prev_q  <= pin_s;
      level_q <= level_mode;
      if (fall)         edge_q <= 1'b1;
      else if (irq_ack) edge_q <= 1'b0;
    end
  end

  assign irq_status = edge_q | (level_q & ~pin_s);
  assign irq_req    = irq_status & ~cpu_imask;

endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic irq_ack,
  input logic cpu_imask,
  input logic irq_req,
  input logic irq_status,
  input logic level_q,
  input logic edge_q,
  input logic fall,
  input logic pin_s,
  input logic prev_q
);

  AST_REQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) cpu_imask |-> !irq_req); // R5
  AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) !cpu_imask |-> (irq_req == irq_status)); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (irq_ack && !fall) |=> !edge_q); // R6
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n) fall |=> edge_q); // R7
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (edge_q && !irq_ack) |=> edge_q); // R2
  AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) !level_q |-> (irq_status == edge_q)); // R3
  AST_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n) (level_q && !pin_s) |-> irq_status); // R4
  AST_NO_RISE_SET: assert property (@(posedge clk) disable iff (!rst_n) (!edge_q && !prev_q && pin_s) |=> !edge_q); // R8

endmodule

bind ext_irq_detect ext_irq_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .cpu_imask(cpu_imask),
  .irq_req(irq_req), .irq_status(irq_status), .level_q(level_q),
  .edge_q(edge_q), .fall(fall), .pin_s(pin_s), .prev_q(prev_q)
);

// File: tb/test_ext_irq_detect.sv
module test_ext_irq_detect;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_pin_n = 1'b1;
  logic level_mode = 1'b0;
  logic cpu_imask = 1'b0;
  logic irq_ack = 1'b0;
  logic irq_req;
  logic irq_status;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_irq_detect i_ext_irq_detect (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .level_mode(level_mode),
    .cpu_imask(cpu_imask), .irq_ack(irq_ack), .irq_req(irq_req), .irq_status(irq_status)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    tick(1);
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    irq_pin_n = 1'b1;
    rst_n = 1'b0;
    tick(3);
    chk("R1", "status in reset", irq_status, 1'b0);
    chk("R1", "req in reset", irq_req, 1'b0);
    rst_n = 1'b1;
    tick(2);
    chk("R1", "status after reset", irq_status, 1'b0);
    chk("R1", "req after reset", irq_req, 1'b0);
  endtask

  task automatic t_edge_only();
    level_mode = 1'b0;
    tick(1);
    irq_pin_n = 1'b0;
    tick(2);
    chk("R2", "status one cycle early", irq_status, 1'b0);
    tick(1);
    chk("R2", "status on third edge", irq_status, 1'b1);
    chk("R5", "req unmasked", irq_req, 1'b1);
    irq_pin_n = 1'b1;
    tick(4);
    chk("R2", "held after pin high", irq_status, 1'b1);
    chk("R8", "rise leaves latch set", irq_status, 1'b1);
    ack_pulse();
    chk("R6", "ack clears latch", irq_status, 1'b0);
    tick(3);
    chk("R8", "no set from idle/rise", irq_status, 1'b0);
  endtask

  task automatic t_level_ignored();
    level_mode = 1'b0;
    tick(1);
    irq_pin_n = 1'b0;
    tick(3);
    chk("R3", "edge latched", irq_status, 1'b1);
    ack_pulse();
    chk("R3", "cleared while low", irq_status, 1'b0);
    tick(5);
    chk("R3", "low level ignored", irq_status, 1'b0);
    chk("R3", "req low level ignored", irq_req, 1'b0);
    irq_pin_n = 1'b1;
    tick(4);
    chk("R8", "rising edge no set", irq_status, 1'b0);
  endtask

  task automatic t_level();
    level_mode = 1'b1;
    tick(1);
    irq_pin_n = 1'b0;
    tick(1);
    chk("R4", "not yet at first edge", irq_status, 1'b0);
    tick(1);
    chk("R4", "level on second edge", irq_status, 1'b1);
    tick(1);
    ack_pulse();
    chk("R4", "reasserts while low", irq_status, 1'b1);
    tick(2);
    chk("R4", "still asserted", irq_status, 1'b1);
    irq_pin_n = 1'b1;
    tick(2);
    chk("R4", "drops when pin high", irq_status, 1'b0);
    irq_pin_n = 1'b0;
    tick(1);
    irq_pin_n = 1'b1;
    tick(5);
    chk("R4", "short pulse latched", irq_status, 1'b1);
    ack_pulse();
    chk("R6", "ack clears level-mode latch", irq_status, 1'b0);
    level_mode = 1'b0;
    tick(2);
  endtask

  task automatic t_mask();
    irq_pin_n = 1'b0;
    tick(3);
    cpu_imask = 1'b1;
    #1;
    chk("R5", "status while masked", irq_status, 1'b1);
    chk("R5", "req masked", irq_req, 1'b0);
    tick(2);
    chk("R5", "req stays masked", irq_req, 1'b0);
    cpu_imask = 1'b0;
    #1;
    chk("R5", "req after unmask", irq_req, 1'b1);
    irq_pin_n = 1'b1;
    tick(1);
    ack_pulse();
    chk("R5", "req after ack", irq_req, 1'b0);
    tick(3);
  endtask

  task automatic t_collision();
    irq_pin_n = 1'b0;
    tick(3);
    irq_pin_n = 1'b1;
    tick(3);
    chk("R7", "latch set before", irq_status, 1'b1);
    irq_pin_n = 1'b0;
    tick(2);
    ack_pulse();
    chk("R7", "edge beats ack", irq_status, 1'b1);
    tick(3);
    chk("R7", "still set", irq_status, 1'b1);
    ack_pulse();
    chk("R6", "later ack clears", irq_status, 1'b0);
    irq_pin_n = 1'b1;
    tick(3);
  endtask

  initial begin
    t_reset();
    t_edge_only();
    t_level_ignored();
    t_level();
    t_mask();
    t_collision();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule